// File: doc/BRIEF.md
# Processor Interrupt Level Resolver

This block decides, once per clock, whether the processor should take an external-level interrupt and which trap type it should carry. It merges a 16-bit vector of external level requests with the level bits of a software interrupt register. The register's two timer-match bits are removed from that merge and raise level 14 in their place. The resolver then picks the highest pending level that is strictly above the current processor interrupt level.

A chosen level produces a registered request with trap type `0x40 | level`. Several conditions hold the previous decision or drop the request. A busy vectored interrupt freezes both outputs. A nested external trap of higher type blocks a new request while the trap level is nonzero. A disabled global enable, or the absence of any level above the current one, clears the request and the trap type to zero. The trap handler consumes the outputs. The registers that feed the inputs are maintained elsewhere.

Top module: `irq_level_resolver`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls with no levels pending, `irq_req` is 0 and `irq_tt` is 0.
- R2: The pending mask is `ext_lvl` ORed with `soft_reg[15:1]` placed on levels 15..1. Software bit 0 never contributes level 0, and bit 16 never contributes a level of its own.
- R3: If `soft_reg[0]` (tick match) or `soft_reg[16]` (system-tick match) is set, level 14 is pending.
- R4: With `int_en`=1 and `vec_busy`=0, the highest pending level L above `cur_pil` sets `irq_req`=1 and `irq_tt`=0x40|L at the next clock edge.
- R5: If no pending level is above `cur_pil` and `vec_busy`=0, `irq_req` and `irq_tt` become 0 at the next edge, whatever `int_en` is.
- R6: With `int_en`=0 and `vec_busy`=0, an active request is withdrawn: `irq_req`=0 and `irq_tt`=0 at the next edge.
- R7: While `vec_busy`=1, `irq_req` and `irq_tt` hold their values whatever the other inputs do.
- R8: A new trap type T is not taken, and the outputs hold, when all three of these are true: `trap_lvl`≠0, `cur_tt[8:4]`=4 (an external-level trap), and `cur_tt`>T. If any one of them is false, T is taken.
- R9: A pending level equal to `cur_pil` is ignored.
- R10: While a request is active, a change of the highest pending level changes `irq_tt` to the new level at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_lvl | input | 16 | External level requests, bit n = level n |
| soft_reg | input | 17 | Bit 0 tick match, bits 15:1 software levels, bit 16 system-tick match |
| cur_pil | input | 4 | Current processor interrupt level |
| int_en | input | 1 | Global interrupt enable |
| vec_busy | input | 1 | Vectored interrupt outstanding |
| trap_lvl | input | 3 | Current trap nesting level |
| cur_tt | input | 9 | Trap type of the trap in progress |
| irq_req | output | 1 | Hard interrupt request |
| irq_tt | output | 9 | Selected trap type, 0 when idle |

## Verification
A wrong latched trap type shows on `irq_tt` one edge after the stimulus that should have set it. Because the request is only re-raised on a change of type, a stale latch can also hide a later legal update. A freeze or nesting fault shows as an output that moves when it must hold, or holds when it must move, one cycle after the inputs change. For that reason every scenario compares both outputs on the first edge after each input step.

// File: rtl/ilr_pkg.sv
package ilr_pkg;
    localparam int NUM_LVL   = 16;
    localparam int LVL_W     = $clog2(NUM_LVL);
    localparam int SOFT_W    = NUM_LVL + 1;
    localparam int TT_W      = 9;
    localparam int TL_W      = 3;
    localparam int TIMER_LVL = 14;
    localparam logic [TT_W-1:0] EXTINT = 9'h040;

    typedef logic [TT_W-1:0]  tt_t;
    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        logic hit;
        lvl_t lvl;
    } pick_t;

    typedef struct packed {
        logic req;
        tt_t  tt;
    } irq_state_t;

    function automatic tt_t make_tt(lvl_t l);
        return EXTINT | tt_t'(l);
    endfunction
endpackage

// File: rtl/ilr_pend_mask.sv
module ilr_pend_mask #(
    parameter int NUM_LVL   = ilr_pkg::NUM_LVL,
    parameter int TIMER_LVL = ilr_pkg::TIMER_LVL
) (
    input  logic [NUM_LVL-1:0] ext_lvl,
    input  logic [NUM_LVL:0]   soft_reg,
    output logic [NUM_LVL-1:0] pend
);
    logic [NUM_LVL-1:0] soft_lv;
    logic               timer_hit;

    always_comb begin
        soft_lv    = soft_reg[NUM_LVL-1:0];
        soft_lv[0] = 1'b0;
        timer_hit  = soft_reg[0] | soft_reg[NUM_LVL];
        pend       = ext_lvl | soft_lv;
        if (timer_hit)
            pend[TIMER_LVL] = 1'b1;
    end
endmodule

// File: rtl/ilr_level_scan.sv
module ilr_level_scan #(
    parameter int NUM_LVL = ilr_pkg::NUM_LVL,
    localparam int LVL_W  = $clog2(NUM_LVL)
) (
    input  logic [NUM_LVL-1:0] pend,
    input  logic [LVL_W-1:0]   pil,
    output logic               hit,
    output logic [LVL_W-1:0]   lvl
);
    logic [NUM_LVL-1:0] above;

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_above
        assign above[g] = pend[g] && ((LVL_W+1)'(g) > {1'b0, pil});
    end

    always_comb begin
        hit = 1'b0;
        lvl = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (above[i]) begin
                hit = 1'b1;
                lvl = i[LVL_W-1:0];
            end
        end
    end
endmodule

// File: rtl/ilr_nest_guard.sv
module ilr_nest_guard #(
    parameter int TT_W  = ilr_pkg::TT_W,
    parameter int TL_W  = ilr_pkg::TL_W,
    parameter int LVL_W = ilr_pkg::LVL_W,
    parameter logic [TT_W-1:0] EXTINT = ilr_pkg::EXTINT
) (
    input  logic [TL_W-1:0] trap_lvl,
    input  logic [TT_W-1:0] cur_tt,
    input  logic [TT_W-1:0] new_tt,
    output logic            block
);
    logic nested, ext_class, higher;

    always_comb begin
        nested    = trap_lvl != '0;
        ext_class = cur_tt[TT_W-1:LVL_W] == EXTINT[TT_W-1:LVL_W];
        higher    = cur_tt > new_tt;
        block     = nested && ext_class && higher;
    end
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
    import ilr_pkg::*;
#(
    parameter int N_LVL = ilr_pkg::NUM_LVL,
    localparam int LW   = $clog2(N_LVL)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_LVL-1:0]     ext_lvl,
    input  logic [N_LVL:0]       soft_reg,
    input  logic [LW-1:0]        cur_pil,
    input  logic                 int_en,
    input  logic                 vec_busy,
    input  logic [TL_W-1:0]      trap_lvl,
    input  logic [TT_W-1:0]      cur_tt,
    output logic                 irq_req,
    output logic [TT_W-1:0]      irq_tt
);
    logic [N_LVL-1:0] pend;
    pick_t            pick;
    tt_t              new_tt;
    logic             blocked;
    irq_state_t       st_q, st_d;

    ilr_pend_mask #(.NUM_LVL(N_LVL), .TIMER_LVL(TIMER_LVL)) u_mask (
        .ext_lvl (ext_lvl),
        .soft_reg(soft_reg),
        .pend    (pend)
    );

    ilr_level_scan #(.NUM_LVL(N_LVL)) u_scan (
        .pend(pend),
        .pil (cur_pil),
        .hit (pick.hit),
        .lvl (pick.lvl)
    );

    assign new_tt = make_tt(pick.lvl);

    ilr_nest_guard #(.TT_W(TT_W), .TL_W(TL_W), .LVL_W(LW), .EXTINT(EXTINT)) u_guard (
        .trap_lvl(trap_lvl),
        .cur_tt  (cur_tt),
        .new_tt  (new_tt),
        .block   (blocked)
    );

    always_comb begin
        st_d = st_q;
        if (!vec_busy) begin
            if (!pick.hit) begin
                st_d = '{req: 1'b0, tt: '0};
            end else if (int_en) begin
                if (!blocked && (st_q.tt != new_tt))
                    st_d = '{req: 1'b1, tt: new_tt};
            end else if (st_q.req) begin
                st_d = '{req: 1'b0, tt: '0};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{req: 1'b0, tt: '0};
        else     st_q <= st_d;
    end

    assign irq_req = st_q.req;
    assign irq_tt  = st_q.tt;
endmodule

// File: rtl/irq_level_resolver_chk.sv
module irq_level_resolver_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] ext_lvl,
    input logic [16:0] soft_reg,
    input logic [3:0]  cur_pil,
    input logic        int_en,
    input logic        vec_busy,
    input logic [2:0]  trap_lvl,
    input logic [8:0]  cur_tt,
    input logic        irq_req,
    input logic [8:0]  irq_tt
);
    logic [15:0] lv;
    logic        none_above;
    always_comb begin
        lv = ext_lvl | {soft_reg[15:1], 1'b0} | ((soft_reg[0] || soft_reg[16]) ? 16'h4000 : 16'h0);
        none_above = ((lv >> cur_pil) >> 1) == 16'h0;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !irq_req && irq_tt == 9'h0); // R1
    AST_REQ_PAIRED: assert property (@(posedge clk) disable iff (rst) irq_req == (irq_tt != 9'h0)); // R4
    AST_TT_CLASS:   assert property (@(posedge clk) disable iff (rst) irq_req |-> irq_tt[8:4] == 5'h4 && irq_tt[3:0] != 4'h0); // R4
    AST_NONE_CLEAR: assert property (@(posedge clk) disable iff (rst) (!vec_busy && none_above) |=> !irq_req); // R5
    AST_DIS_CLEAR:  assert property (@(posedge clk) disable iff (rst) (!vec_busy && !int_en) |=> !irq_req); // R6
    AST_BUSY_HOLD:  assert property (@(posedge clk) disable iff (rst) vec_busy |=> $stable(irq_req) && $stable(irq_tt)); // R7
    AST_ABOVE_PIL:  assert property (@(posedge clk) disable iff (rst) $rose(irq_req) |-> irq_tt[3:0] > $past(cur_pil)); // R9
endmodule

bind irq_level_resolver irq_level_resolver_chk u_chk (.*);

// File: tb/irq_level_resolver_bench.sv
module irq_level_resolver_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] ext_lvl;
    logic [16:0] soft_reg;
    logic [3:0]  cur_pil;
    logic        int_en, vec_busy;
    logic [2:0]  trap_lvl;
    logic [8:0]  cur_tt;
    logic        irq_req;
    logic [8:0]  irq_tt;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    irq_level_resolver u_irq_level_resolver (.*);

    task automatic expect_out(string req, logic er, logic [8:0] et);
        checks++;
        if (irq_req !== er || irq_tt !== et) begin
            errors++;
            $display("FAIL %s: req=%0b tt=%h expected req=%0b tt=%h", req, irq_req, irq_tt, er, et);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        ext_lvl = '0; soft_reg = '0; cur_pil = '0; int_en = 1'b1;
        vec_busy = 1'b0; trap_lvl = '0; cur_tt = '0;
    endtask

    task automatic t_reset();
        idle_inputs();
        rst = 1'b1;
        step(); step();
        expect_out("R1 in reset", 1'b0, 9'h0);
        @(negedge clk) rst = 1'b0;
        step();
        expect_out("R1 after reset", 1'b0, 9'h0);
    endtask

    task automatic t_basic();
        @(negedge clk) begin ext_lvl = 16'h0020; cur_pil = 4'd2; end
        step(); expect_out("R4 level 5", 1'b1, 9'h045);
        @(negedge clk) begin ext_lvl = 16'h1208; cur_pil = 4'd0; end
        step(); expect_out("R4 highest of 3,9,12", 1'b1, 9'h04C);
    endtask

    task automatic t_eq_pil();
        @(negedge clk) begin ext_lvl = 16'h0010; cur_pil = 4'd4; end
        step(); expect_out("R9 R5 level equal pil", 1'b0, 9'h0);
        @(negedge clk) begin ext_lvl = 16'h0010; cur_pil = 4'd3; end
        step(); expect_out("R9 level above pil", 1'b1, 9'h044);
    endtask

    task automatic t_soft();
        @(negedge clk) begin ext_lvl = '0; cur_pil = 4'd0; soft_reg = 17'h00080; end
        step(); expect_out("R2 soft level 7", 1'b1, 9'h047);
        @(negedge clk) begin soft_reg = 17'h00001; cur_pil = 4'd13; end
        step(); expect_out("R3 tick folds to 14", 1'b1, 9'h04E);
        @(negedge clk) begin soft_reg = 17'h10000; cur_pil = 4'd0; ext_lvl = 16'h0004; end
        step(); expect_out("R3 stick folds to 14", 1'b1, 9'h04E);
        @(negedge clk) begin soft_reg = 17'h10001; ext_lvl = '0; cur_pil = 4'd14; end
        step(); expect_out("R2 timer bits give no level 15", 1'b0, 9'h0);
        @(negedge clk) begin soft_reg = 17'h00001; ext_lvl = '0; cur_pil = 4'd0; end
        step(); expect_out("R2 tick bit not level 0", 1'b1, 9'h04E);
        @(negedge clk) soft_reg = '0;
        step(); expect_out("R5 nothing pending", 1'b0, 9'h0);
    endtask

    task automatic t_disable();
        @(negedge clk) begin ext_lvl = 16'h0020; cur_pil = 4'd0; end
        step(); expect_out("R4 setup", 1'b1, 9'h045);
        @(negedge clk) int_en = 1'b0;
        step(); expect_out("R6 disabled clears", 1'b0, 9'h0);
        step(); expect_out("R6 stays clear", 1'b0, 9'h0);
        @(negedge clk) int_en = 1'b1;
        step(); expect_out("R4 re-enabled", 1'b1, 9'h045);
    endtask

    task automatic t_busy();
        @(negedge clk) begin vec_busy = 1'b1; ext_lvl = 16'h0200; end
        step(); expect_out("R7 busy hold on change", 1'b1, 9'h045);
        @(negedge clk) begin ext_lvl = '0; int_en = 1'b0; end
        step(); expect_out("R7 busy hold on clear", 1'b1, 9'h045);
        @(negedge clk) begin ext_lvl = 16'h0200; int_en = 1'b1; vec_busy = 1'b0; end
        step(); expect_out("R7 released", 1'b1, 9'h049);
    endtask

    task automatic t_update();
        @(negedge clk) ext_lvl = 16'h0008;
        step(); expect_out("R10 down to level 3", 1'b1, 9'h043);
        @(negedge clk) ext_lvl = 16'h0808;
        step(); expect_out("R10 up to level 11", 1'b1, 9'h04B);
        @(negedge clk) ext_lvl = 16'h0008;
        step(); expect_out("R10 back to level 3", 1'b1, 9'h043);
    endtask

    task automatic t_nest();
        @(negedge clk) begin trap_lvl = 3'd1; cur_tt = 9'h04C; ext_lvl = 16'h0108; end
        step(); expect_out("R8 blocked keeps old", 1'b1, 9'h043);
        @(negedge clk) ext_lvl = '0;
        step(); expect_out("R5 clear before nest", 1'b0, 9'h0);
        @(negedge clk) begin cur_tt = 9'h04A; ext_lvl = 16'h0040; end
        step(); expect_out("R8 blocked from idle", 1'b0, 9'h0);
        @(negedge clk) cur_tt = 9'h044;
        step(); expect_out("R8 lower nested type", 1'b1, 9'h046);
        @(negedge clk) ext_lvl = '0;
        step(); expect_out("R5 clear", 1'b0, 9'h0);
        @(negedge clk) begin cur_tt = 9'h08F; ext_lvl = 16'h0040; end
        step(); expect_out("R8 non-external type", 1'b1, 9'h046);
        @(negedge clk) ext_lvl = '0;
        step(); expect_out("R5 clear", 1'b0, 9'h0);
        @(negedge clk) begin trap_lvl = 3'd0; cur_tt = 9'h04A; ext_lvl = 16'h0040; end
        step(); expect_out("R8 trap level zero", 1'b1, 9'h046);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_eq_pil();
        t_soft();
        t_disable();
        t_busy();
        t_update();
        t_nest();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule